// File: doc/BRIEF.md
# Dual-Direction Register Mailbox with Doorbell Interrupts

This block holds two banks of 32-bit message words shared by two register ports: a local port on the on-chip memory-mapped fabric and a host port on the link side. Each side owns one bank. It may write that bank, and the other side may only read it. Every store into a word also raises a doorbell bit in the status register of the receiving side. That side clears the bit by writing a 1 to it. A per-side enable register masks the doorbell bits onto a level interrupt for that side.

Both ports share one word-addressed map. Words 0..NUM_BOX-1 hold the local-to-host bank and words NUM_BOX..2*NUM_BOX-1 hold the host-to-local bank. Word 2*NUM_BOX is the doorbell status of the accessing side and word 2*NUM_BOX+1 is its enable register. In both registers, bit STAT_LSB+i belongs to word i of the bank that the other side writes. With the defaults (8 words per bank, STAT_LSB = 16) the status register sits at word 16, the enable register at word 17, and the doorbell field covers bits [23:16]. Read data is registered.

Top module: `dual_mailbox`

## Requirements
- R1: After reset all mailbox words, both status registers, both enable registers, both read-data outputs and both interrupts are zero.
- R2: A local write to word i (0..7) stores the data there, and both ports read it back at word i.
- R3: A host write to word 8+i (i in 0..7) stores the data there, and both ports read it back at word 8+i.
- R4: A write to a bank word owned by the other side is ignored. The word keeps its contents and no doorbell bit is set.
- R5: A store into a bank word i sets bit 16+i of the receiving side's status register (word 16) on the next cycle. The local side receives stores to words 0..7 from the host's point of view as doorbells in the host status; stores to words 8..15 raise doorbells in the local status.
- R6: A side's write to its own word 16 clears every status bit written as 1 and leaves bits written as 0. The write has no effect on the other side's status.
- R7: If a store sets a status bit in the same cycle as a write-1-to-clear of that bit, the bit ends up set.
- R8: Status and enable words read zero outside bits [23:16], and only bits [23:16] of an enable write are kept.
- R9: Each side's interrupt is high exactly when some bit is set in both its status and its enable register.
- R10: A read presents the word's value from before the edge on the read-data output one cycle later. The output holds while no read is made, and unmapped words read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Active-low synchronous reset |
| loc_addr | input | ADDR_W | Local port word address |
| loc_write | input | 1 | Local port write strobe |
| loc_wdata | input | DATA_W | Local port write data |
| loc_read | input | 1 | Local port read strobe |
| loc_rdata | output | DATA_W | Local port registered read data |
| loc_irq | output | 1 | Local doorbell interrupt |
| hst_addr | input | ADDR_W | Host port word address |
| hst_write | input | 1 | Host port write strobe |
| hst_wdata | input | DATA_W | Host port write data |
| hst_read | input | 1 | Host port read strobe |
| hst_rdata | output | DATA_W | Host port registered read data |
| hst_irq | output | 1 | Host doorbell interrupt |

## Verification
The two functions that can meet in one cycle are a store that raises a doorbell bit and a write-1-to-clear of the same status register by the receiving side. The directed part provokes this on purpose: the local side stores to word 5 while the host clears bit 21 in the same cycle. The check expects bit 21 still set and the host interrupt still high. A seeded random phase then drives both ports every cycle, so stores, clears, enable writes and reads overlap freely. A behavioural model in the bench predicts both read-data outputs and both interrupts on every clock.

// File: rtl/dmbx_pkg.sv
package dmbx_pkg;

    typedef enum logic [2:0] {
        RGN_L2H,
        RGN_H2L,
        RGN_STATUS,
        RGN_ENABLE,
        RGN_NONE
    } region_e;

    function automatic region_e decode_region(int unsigned waddr, int unsigned nbox);
        if (waddr < nbox)                 return RGN_L2H;
        else if (waddr < 2 * nbox)        return RGN_H2L;
        else if (waddr == 2 * nbox)       return RGN_STATUS;
        else if (waddr == 2 * nbox + 1)   return RGN_ENABLE;
        else                              return RGN_NONE;
    endfunction

endpackage

// File: rtl/dmbx_store.sv
module dmbx_store #(
    parameter int NUM_BOX = 8,
    parameter int DATA_W  = 32,
    localparam int IDX_W  = $clog2(NUM_BOX)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [IDX_W-1:0]               wr_idx,
    input  logic [DATA_W-1:0]              wr_data,
    output logic [NUM_BOX-1:0][DATA_W-1:0] boxes,
    output logic [NUM_BOX-1:0]             set_vec
);

    for (genvar g = 0; g < NUM_BOX; g++) begin : g_box
        logic hit;
        assign hit        = wr_en && (wr_idx == IDX_W'(g));
        assign set_vec[g] = hit;

        always_ff @(posedge clk) begin
            if (!rst_n)   boxes[g] <= '0;
            else if (hit) boxes[g] <= wr_data;
        end
    end

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(boxes)); // R4

endmodule

// File: rtl/dmbx_irq_ctrl.sv
module dmbx_irq_ctrl #(
    parameter int NUM_BOX = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_BOX-1:0] set_vec,
    input  logic               stat_we,
    input  logic               en_we,
    input  logic [NUM_BOX-1:0] field,
    output logic [NUM_BOX-1:0] status,
    output logic [NUM_BOX-1:0] enable,
    output logic               irq
);

    logic [NUM_BOX-1:0] clr_vec;
    assign clr_vec = stat_we ? field : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= '0;
            enable <= '0;
        end else begin
            status <= (status & ~clr_vec) | set_vec;
            if (en_we) enable <= field;
        end
    end

    assign irq = |(status & enable);

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((status & $past(set_vec)) == $past(set_vec))); // R7

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_we && ((field & ~set_vec) != '0)) |=> ((status & $past(field & ~set_vec)) == '0)); // R6

    AST_STATUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_vec == '0) && !stat_we) |=> $stable(status)); // R5

endmodule

// File: rtl/dmbx_port.sv
module dmbx_port
    import dmbx_pkg::*;
#(
    parameter int NUM_BOX    = 8,
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 5,
    parameter int STAT_LSB   = 16,
    parameter bit OWN_IS_L2H = 1'b1,
    localparam int IDX_W     = $clog2(NUM_BOX)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [ADDR_W-1:0]              addr,
    input  logic                           write,
    input  logic [DATA_W-1:0]              wdata,
    input  logic                           read,
    input  logic [NUM_BOX-1:0][DATA_W-1:0] l2h_boxes,
    input  logic [NUM_BOX-1:0][DATA_W-1:0] h2l_boxes,
    input  logic [NUM_BOX-1:0]             status,
    input  logic [NUM_BOX-1:0]             enable,
    output logic [DATA_W-1:0]              rdata,
    output logic                           box_we,
    output logic [IDX_W-1:0]               box_idx,
    output logic                           stat_we,
    output logic                           en_we,
    output logic [NUM_BOX-1:0]             field
);

    localparam region_e OWN_RGN = OWN_IS_L2H ? RGN_L2H : RGN_H2L;
    localparam logic [DATA_W-1:0] FIELD_MASK = {NUM_BOX{1'b1}} << STAT_LSB;

    region_e           rgn;
    logic [ADDR_W-1:0] offs;
    logic [DATA_W-1:0] rd_next;

    assign rgn     = decode_region(int'(addr), NUM_BOX);
    assign offs    = (rgn == RGN_H2L) ? addr - ADDR_W'(NUM_BOX) : addr;
    assign box_idx = offs[IDX_W-1:0];
    assign box_we  = write && (rgn == OWN_RGN);
    assign stat_we = write && (rgn == RGN_STATUS);
    assign en_we   = write && (rgn == RGN_ENABLE);
    assign field   = wdata[STAT_LSB +: NUM_BOX];

    always_comb begin
        rd_next = '0;
        unique case (rgn)
            RGN_L2H:    rd_next = l2h_boxes[box_idx];
            RGN_H2L:    rd_next = h2l_boxes[box_idx];
            RGN_STATUS: rd_next[STAT_LSB +: NUM_BOX] = status;
            RGN_ENABLE: rd_next[STAT_LSB +: NUM_BOX] = enable;
            RGN_NONE:   rd_next = '0;
            default:    rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)    rdata <= '0;
        else if (read) rdata <= rd_next;
    end

    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (read && ((rgn == RGN_STATUS) || (rgn == RGN_ENABLE))) |=> ((rdata & ~FIELD_MASK) == '0)); // R8

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !read |=> $stable(rdata)); // R10

endmodule

// File: rtl/dual_mailbox.sv
module dual_mailbox #(
    parameter int NUM_BOX  = 8,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 5,
    parameter int STAT_LSB = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] loc_addr,
    input  logic              loc_write,
    input  logic [DATA_W-1:0] loc_wdata,
    input  logic              loc_read,
    output logic [DATA_W-1:0] loc_rdata,
    output logic              loc_irq,
    input  logic [ADDR_W-1:0] hst_addr,
    input  logic              hst_write,
    input  logic [DATA_W-1:0] hst_wdata,
    input  logic              hst_read,
    output logic [DATA_W-1:0] hst_rdata,
    output logic              hst_irq
);

    localparam int IDX_W = $clog2(NUM_BOX);

    logic [NUM_BOX-1:0][DATA_W-1:0] l2h_boxes, h2l_boxes;
    logic [NUM_BOX-1:0]             l2h_set, h2l_set;
    logic [NUM_BOX-1:0]             loc_status, loc_enable, hst_status, hst_enable;
    logic [NUM_BOX-1:0]             loc_field, hst_field;
    logic                           loc_box_we, hst_box_we;
    logic [IDX_W-1:0]               loc_box_idx, hst_box_idx;
    logic                           loc_stat_we, loc_en_we, hst_stat_we, hst_en_we;

    dmbx_port #(.NUM_BOX(NUM_BOX), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
                .STAT_LSB(STAT_LSB), .OWN_IS_L2H(1'b1)) u_loc_port (
        .clk(clk), .rst_n(rst_n), .addr(loc_addr), .write(loc_write),
        .wdata(loc_wdata), .read(loc_read), .l2h_boxes(l2h_boxes),
        .h2l_boxes(h2l_boxes), .status(loc_status), .enable(loc_enable),
        .rdata(loc_rdata), .box_we(loc_box_we), .box_idx(loc_box_idx),
        .stat_we(loc_stat_we), .en_we(loc_en_we), .field(loc_field));

    dmbx_port #(.NUM_BOX(NUM_BOX), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
                .STAT_LSB(STAT_LSB), .OWN_IS_L2H(1'b0)) u_hst_port (
        .clk(clk), .rst_n(rst_n), .addr(hst_addr), .write(hst_write),
        .wdata(hst_wdata), .read(hst_read), .l2h_boxes(l2h_boxes),
        .h2l_boxes(h2l_boxes), .status(hst_status), .enable(hst_enable),
        .rdata(hst_rdata), .box_we(hst_box_we), .box_idx(hst_box_idx),
        .stat_we(hst_stat_we), .en_we(hst_en_we), .field(hst_field));

    dmbx_store #(.NUM_BOX(NUM_BOX), .DATA_W(DATA_W)) u_l2h_store (
        .clk(clk), .rst_n(rst_n), .wr_en(loc_box_we), .wr_idx(loc_box_idx),
        .wr_data(loc_wdata), .boxes(l2h_boxes), .set_vec(l2h_set));

    dmbx_store #(.NUM_BOX(NUM_BOX), .DATA_W(DATA_W)) u_h2l_store (
        .clk(clk), .rst_n(rst_n), .wr_en(hst_box_we), .wr_idx(hst_box_idx),
        .wr_data(hst_wdata), .boxes(h2l_boxes), .set_vec(h2l_set));

    dmbx_irq_ctrl #(.NUM_BOX(NUM_BOX)) u_loc_irq (
        .clk(clk), .rst_n(rst_n), .set_vec(h2l_set), .stat_we(loc_stat_we),
        .en_we(loc_en_we), .field(loc_field), .status(loc_status),
        .enable(loc_enable), .irq(loc_irq));

    dmbx_irq_ctrl #(.NUM_BOX(NUM_BOX)) u_hst_irq (
        .clk(clk), .rst_n(rst_n), .set_vec(l2h_set), .stat_we(hst_stat_we),
        .en_we(hst_en_we), .field(hst_field), .status(hst_status),
        .enable(hst_enable), .irq(hst_irq));

    AST_HOST_CANNOT_WRITE_L2H: assert property (@(posedge clk) disable iff (!rst_n)
        (hst_write && (hst_addr < ADDR_W'(NUM_BOX)) && !loc_write) |=> $stable(l2h_boxes)); // R4

    AST_LOCAL_CANNOT_WRITE_H2L: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_write && (loc_addr >= ADDR_W'(NUM_BOX)) && (loc_addr < ADDR_W'(2*NUM_BOX)) && !hst_write)
        |=> $stable(h2l_boxes)); // R4

    AST_DOORBELL_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_write && (loc_addr < ADDR_W'(NUM_BOX))) |=> hst_status[$past(loc_addr[IDX_W-1:0])]); // R5

endmodule

// File: tb/dual_mailbox_tb.sv
module dual_mailbox_tb_top;

    localparam int N  = 8;
    localparam int DW = 32;
    localparam int AW = 5;
    localparam int SL = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] loc_addr = '0, hst_addr = '0;
    logic          loc_write = 1'b0, loc_read = 1'b0, hst_write = 1'b0, hst_read = 1'b0;
    logic [DW-1:0] loc_wdata = '0, hst_wdata = '0;
    logic [DW-1:0] loc_rdata, hst_rdata;
    logic          loc_irq, hst_irq;

    int checks = 0;
    int failures = 0;
    bit model_on = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    dual_mailbox #(.NUM_BOX(N), .DATA_W(DW), .ADDR_W(AW), .STAT_LSB(SL)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .loc_addr(loc_addr), .loc_write(loc_write), .loc_wdata(loc_wdata),
        .loc_read(loc_read), .loc_rdata(loc_rdata), .loc_irq(loc_irq),
        .hst_addr(hst_addr), .hst_write(hst_write), .hst_wdata(hst_wdata),
        .hst_read(hst_read), .hst_rdata(hst_rdata), .hst_irq(hst_irq));

    // Behavioural reference model
    logic [DW-1:0] m_l2h [N];
    logic [DW-1:0] m_h2l [N];
    logic [N-1:0]  m_lst, m_len, m_hst, m_hen;
    logic [DW-1:0] m_lrd, m_hrd;

    function automatic logic [DW-1:0] model_read(bit is_loc, int a);
        logic [DW-1:0] v = '0;
        if (a < N)            v = m_l2h[a];
        else if (a < 2*N)     v = m_h2l[a-N];
        else if (a == 2*N)    v[SL +: N] = is_loc ? m_lst : m_hst;
        else if (a == 2*N+1)  v[SL +: N] = is_loc ? m_len : m_hen;
        return v;
    endfunction

    task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        logic [N-1:0] set_l, set_h, clr_l, clr_h;
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin m_l2h[i] = '0; m_h2l[i] = '0; end
            m_lst = '0; m_len = '0; m_hst = '0; m_hen = '0; m_lrd = '0; m_hrd = '0;
        end else begin
            if (loc_read) m_lrd = model_read(1'b1, int'(loc_addr));
            if (hst_read) m_hrd = model_read(1'b0, int'(hst_addr));
            set_h = '0; set_l = '0; clr_l = '0; clr_h = '0;
            if (loc_write && loc_addr < N) begin
                m_l2h[loc_addr] = loc_wdata; set_h[loc_addr] = 1'b1;
            end
            if (hst_write && hst_addr >= N && hst_addr < 2*N) begin
                m_h2l[hst_addr-N] = hst_wdata; set_l[hst_addr-N] = 1'b1;
            end
            if (loc_write && loc_addr == 2*N)   clr_l = loc_wdata[SL +: N];
            if (hst_write && hst_addr == 2*N)   clr_h = hst_wdata[SL +: N];
            if (loc_write && loc_addr == 2*N+1) m_len = loc_wdata[SL +: N];
            if (hst_write && hst_addr == 2*N+1) m_hen = hst_wdata[SL +: N];
            m_lst = (m_lst & ~clr_l) | set_l;
            m_hst = (m_hst & ~clr_h) | set_h;
        end
        #1.5;
        if (model_on) begin
            check("R10 loc_rdata", loc_rdata, m_lrd);
            check("R10 hst_rdata", hst_rdata, m_hrd);
            check("R9 loc_irq", DW'(loc_irq), DW'(|(m_lst & m_len)));
            check("R9 hst_irq", DW'(hst_irq), DW'(|(m_hst & m_hen)));
        end
    end

    task automatic cyc(input logic lw, input int la, input logic [DW-1:0] lwd, input logic lr,
                       input logic hw, input int ha, input logic [DW-1:0] hwd, input logic hr);
        @(negedge clk);
        loc_write = lw; loc_addr = AW'(la); loc_wdata = lwd; loc_read = lr;
        hst_write = hw; hst_addr = AW'(ha); hst_wdata = hwd; hst_read = hr;
        @(posedge clk);
        #2;
        @(negedge clk);
        loc_write = 0; loc_read = 0; hst_write = 0; hst_read = 0;
        #0.5;
    endtask

    task automatic lwr(int a, logic [DW-1:0] d); cyc(1, a, d, 0, 0, 0, 0, 0); endtask
    task automatic hwr(int a, logic [DW-1:0] d); cyc(0, 0, 0, 0, 1, a, d, 0); endtask
    task automatic lrd(int a); cyc(0, 0, 0, 1, 0, 0, 0, 0); endtask
    task automatic rd_both(int a); cyc(0, a, 0, 1, 0, a, 0, 1); endtask

    initial begin
        #40000;
        if (!done) begin
            failures++; checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #0.5;
        // R1: reset state
        check("R1 loc_rdata", loc_rdata, 0);
        check("R1 hst_rdata", hst_rdata, 0);
        check("R1 irqs", DW'({loc_irq, hst_irq}), 0);
        model_on = 1;
        rd_both(16);
        check("R1 status", loc_rdata | hst_rdata, 0);

        // R2: local store readable from both sides
        lwr(3, 32'hA5A5_0003);
        rd_both(3);
        check("R2 loc view", loc_rdata, 32'hA5A5_0003);
        check("R2 hst view", hst_rdata, 32'hA5A5_0003);
        rd_both(16);
        check("R5 host doorbell", hst_rdata, 32'h0008_0000);
        check("R5 local untouched", loc_rdata, 32'h0);

        // R3: host store readable from both sides
        hwr(10, 32'h1234_5678);
        rd_both(10);
        check("R3 loc view", loc_rdata, 32'h1234_5678);
        check("R3 hst view", hst_rdata, 32'h1234_5678);
        rd_both(16);
        check("R5 local doorbell", loc_rdata, 32'h0004_0000);

        // R4: wrong-side writes ignored
        hwr(3, 32'hDEAD_BEEF);
        lwr(10, 32'hCAFE_F00D);
        rd_both(3);
        check("R4 l2h kept", hst_rdata, 32'hA5A5_0003);
        rd_both(10);
        check("R4 h2l kept", loc_rdata, 32'h1234_5678);
        rd_both(16);
        check("R4 host status", hst_rdata, 32'h0008_0000);
        check("R4 local status", loc_rdata, 32'h0004_0000);

        // R8 / R9: enable masking
        check("R9 irq before enable", DW'({loc_irq, hst_irq}), 0);
        hwr(17, 32'hFFFF_FFFF);
        cyc(0, 0, 0, 0, 0, 17, 0, 1);
        check("R8 enable field only", hst_rdata, 32'h00FF_0000);
        check("R9 hst_irq high", DW'(hst_irq), 1);
        check("R9 loc_irq low", DW'(loc_irq), 0);

        // R6: clear semantics
        hwr(16, 32'h0000_0000);
        check("R6 zero keeps", DW'(hst_irq), 1);
        lwr(16, 32'hFFFF_FFFF);
        check("R6 other side no clear", DW'(hst_irq), 1);
        rd_both(16);
        check("R6 local cleared", loc_rdata, 32'h0);
        check("R6 host kept", hst_rdata, 32'h0008_0000);
        hwr(16, 32'hFFFF_FFFF);
        check("R6 host cleared irq", DW'(hst_irq), 0);

        // R7: set and clear collide
        cyc(1, 5, 32'h5555_0005, 0, 1, 16, 32'h0020_0000, 0);
        check("R7 set wins irq", DW'(hst_irq), 1);
        cyc(0, 0, 0, 0, 0, 16, 0, 1);
        check("R7 set wins status", hst_rdata, 32'h0020_0000);

        // R10: hold and unmapped
        cyc(0, 0, 0, 0, 0, 0, 0, 0);
        check("R10 hold", hst_rdata, 32'h0020_0000);
        rd_both(20);
        check("R10 unmapped", loc_rdata | hst_rdata, 32'h0);

        // Random overlap phase (R5, R6, R7, R9, R10 via model)
        for (int k = 0; k < 400; k++) begin
            cyc($urandom_range(0, 1), $urandom_range(0, 19), $urandom, $urandom_range(0, 1),
                $urandom_range(0, 1), $urandom_range(0, 19), $urandom, $urandom_range(0, 1));
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule